// File: doc/BRIEF.md
# Byte-Synchronous Sync Hunter and Preamble Sender

This block handles character alignment for a byte-oriented synchronous serial link. On the receive side it starts in hunt mode and scans the incoming bit stream for a programmable sync pattern. The pattern length is 4, 8 or 16 bits. A fourth mode replaces the match with an external alignment strobe. Once aligned, it packs the following bits, least significant bit first, into 8-bit characters and flags each one with a single-cycle strobe. A restart command drops the receiver back into hunt mode at any time.

On the transmit side, a frame-start request makes the block shift out the complete 16-bit pattern register, least significant bit first, one bit per clock. A short pattern repeated across the low bits of the register therefore goes out as several back-to-back copies. A done pulse marks the final preamble bit, so frame data can follow on the next cycle with no gap. In external-strobe mode no preamble is sent and the done pulse follows the request at once.

Top module: `bsync_framer`

## Requirements
- R1: After reset `in_hunt` is 1, `char_stb` is 0, `tx_active` is 0, `tx_pre_done` is 0 and `tx_bit` idles at 1.
- R2: With `len_sel` equal to 01, 10 or 11 (N = 4, 8 or 16), hunt ends in the cycle after the valid bit that makes the last N bits received since hunt began equal `sync_pat[N-1:0]`. The comparison runs in arrival order: the oldest of those N bits matches `sync_pat[0]`. Hunt never ends before N bits have arrived since it began.
- R3: With `len_sel` 00, received bits never end hunt. A cycle with `ext_sync` high during hunt ends it, and the first valid bit after that cycle is bit 0 of the first character.
- R4: Once out of hunt, every eighth valid bit completes a character whose bit k is the k-th bit received. `char_out` holds that character and `char_stb` is high for exactly the next cycle.
- R5: A cycle with `hunt_restart` high returns the receiver to hunt in the next cycle, discards any partial character, suppresses `char_stb`, and restarts the count of bits seen in hunt.
- R6: For any nonzero `len_sel`, a `tx_start` cycle while idle makes `tx_active` high for the next 16 cycles. In cycle i of those 16, `tx_bit` carries `sync_pat[i]`.
- R7: `tx_pre_done` is high only in the cycle carrying `sync_pat[15]`. With `len_sel` 00, `tx_start` sends no bits and `tx_pre_done` is high in the following cycle instead.
- R8: `tx_start` during an active preamble has no effect on the bit sequence or its length.
- R9: `ext_sync` has no effect in pattern modes, and none in mode 00 once the receiver is out of hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| rx_vld | input | 1 | `rx_bit` is valid this cycle |
| ext_sync | input | 1 | External alignment strobe (mode 00) |
| len_sel | input | 2 | 00 external, 01 4-bit, 10 8-bit, 11 16-bit pattern |
| sync_pat | input | 16 | Sync pattern register |
| hunt_restart | input | 1 | Return to hunt mode |
| char_out | output | 8 | Last assembled character |
| char_stb | output | 1 | One-cycle pulse: `char_out` is new |
| in_hunt | output | 1 | Receiver is hunting for sync |
| tx_start | input | 1 | Request a preamble ahead of a frame |
| tx_bit | output | 1 | Transmitted serial bit |
| tx_active | output | 1 | Preamble bits are being sent |
| tx_pre_done | output | 1 | Last preamble bit, or mode-00 acknowledge |

## Verification
The bench builds the block with its defaults: a 16-bit pattern register and 8-bit characters. These give the three pattern lengths 4, 8 and 16, so every match width is exercised with random noise ahead of the pattern. Accidental early matches inside that noise are predicted by the bench model, as are the repeated short-pattern preambles.

// File: rtl/bsync_framer.sv
module bsync_framer #(
  parameter int PAT_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_vld,
  input  logic              ext_sync,
  input  logic [1:0]        len_sel,
  input  logic [PAT_W-1:0]  sync_pat,
  input  logic              hunt_restart,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_stb,
  output logic              in_hunt,
  input  logic              tx_start,
  output logic              tx_bit,
  output logic              tx_active,
  output logic              tx_pre_done
);
  localparam int QW = PAT_W / 4;
  localparam int HW = PAT_W / 2;
  localparam int FW = $clog2(PAT_W + 1);
  localparam int BW = $clog2(CHAR_W);
  localparam int TW = $clog2(PAT_W);

  logic [PAT_W-1:0]  hist, win;
  logic [FW-1:0]     fill, fill_nx, nlen;
  logic [CHAR_W-1:0] csh;
  logic [BW-1:0]     bcnt;
  logic              sel_match, match;

  assign win     = {rx_bit, hist[PAT_W-1:1]};
  assign fill_nx = (fill == FW'(PAT_W)) ? fill : fill + 1'b1;

  always_comb begin
    case (len_sel)
      2'b01:   begin nlen = FW'(QW);    sel_match = (win[PAT_W-1 -: QW] == sync_pat[QW-1:0]); end
      2'b10:   begin nlen = FW'(HW);    sel_match = (win[PAT_W-1 -: HW] == sync_pat[HW-1:0]); end
      2'b11:   begin nlen = FW'(PAT_W); sel_match = (win == sync_pat); end
      default: begin nlen = FW'(PAT_W); sel_match = 1'b0; end
    endcase
  end

  assign match = rx_vld && (len_sel != 2'b00) && (fill_nx >= nlen) && sel_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hunt  <= 1'b1;
      hist     <= '0;
      fill     <= '0;
      csh      <= '0;
      bcnt     <= '0;
      char_out <= '0;
      char_stb <= 1'b0;
    end else begin
      char_stb <= 1'b0;
      if (hunt_restart) begin
        in_hunt <= 1'b1;
        fill    <= '0;
        bcnt    <= '0;
      end else if (in_hunt) begin
        if (rx_vld) begin
          hist <= win;
          fill <= fill_nx;
        end
        if ((len_sel == 2'b00 && ext_sync) || match) begin
          in_hunt <= 1'b0;
          bcnt    <= '0;
        end
      end else if (rx_vld) begin
        csh <= {rx_bit, csh[CHAR_W-1:1]};
        if (bcnt == BW'(CHAR_W - 1)) begin
          bcnt     <= '0;
          char_out <= {rx_bit, csh[CHAR_W-1:1]};
          char_stb <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  logic [PAT_W-1:0] tx_sh;
  logic [TW-1:0]    tx_cnt;
  logic             ack0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      tx_cnt    <= '0;
      tx_active <= 1'b0;
      ack0      <= 1'b0;
    end else begin
      ack0 <= 1'b0;
      if (tx_active) begin
        tx_sh  <= tx_sh >> 1;
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == TW'(PAT_W - 1)) tx_active <= 1'b0;
      end else if (tx_start) begin
        if (len_sel != 2'b00) begin
          tx_sh     <= sync_pat;
          tx_cnt    <= '0;
          tx_active <= 1'b1;
        end else begin
          ack0 <= 1'b1;
        end
      end
    end
  end

  assign tx_bit      = tx_active ? tx_sh[0] : 1'b1;
  assign tx_pre_done = (tx_active && tx_cnt == TW'(PAT_W - 1)) || ack0;
endmodule

// File: rtl/bsync_framer_chk.sv
module bsync_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_vld,
  input logic       ext_sync,
  input logic [1:0] len_sel,
  input logic       hunt_restart,
  input logic       char_stb,
  input logic       in_hunt,
  input logic       tx_start,
  input logic       tx_active,
  input logic       tx_pre_done
);
  p_hunt_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_hunt) |-> (($past(len_sel) == 2'b00 && $past(ext_sync)) ||
                        ($past(len_sel) != 2'b00 && $past(rx_vld))));

  p_stb_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_stb |-> $past(!in_hunt));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_restart |=> (in_hunt && !char_stb));

  p_tx_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> ($past(tx_start) && $past(len_sel) != 2'b00));

  p_tx_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> $past(tx_pre_done));
endmodule

bind bsync_framer bsync_framer_chk u_chk (.*);

// File: tb/sim_bsync_framer.sv
`timescale 1ns/1ps
module sim_bsync_framer;
  logic clk = 0, rst_n = 0;
  logic rx_bit = 0, rx_vld = 0, ext_sync = 0, hunt_restart = 0, tx_start = 0;
  logic [1:0] len_sel = 2'b11;
  logic [15:0] sync_pat = '0;
  logic [7:0] char_out;
  logic char_stb, in_hunt, tx_bit, tx_active, tx_pre_done;

  bsync_framer u0 (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_win;
  int m_fill, m_cnt;
  bit m_hunt;
  logic [7:0] m_char;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int plen(input logic [1:0] s);
    return (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 16;
  endfunction

  function automatic bit win_hit(input logic [15:0] w, input logic [15:0] p, input int n);
    for (int i = 0; i < n; i++) if (w[16-n+i] != p[i]) return 0;
    return 1;
  endfunction

  task automatic send_bit(input bit b);
    bit exp_stb = 0;
    @(negedge clk);
    rx_bit = b; rx_vld = 1;
    if (m_hunt) begin
      m_win = {b, m_win[15:1]};
      if (m_fill < 16) m_fill++;
      if (len_sel != 2'b00 && m_fill >= plen(len_sel) && win_hit(m_win, sync_pat, plen(len_sel))) begin
        m_hunt = 0; m_cnt = 0;
      end
    end else begin
      m_char = {b, m_char[7:1]};
      m_cnt++;
      if (m_cnt == 8) begin exp_stb = 1; m_cnt = 0; end
    end
    @(negedge clk);
    rx_vld = 0;
    chk(in_hunt == m_hunt, "R2/R3 hunt state", in_hunt, m_hunt);
    chk(char_stb == exp_stb, "R4 char strobe", char_stb, exp_stb);
    if (exp_stb) chk(char_out == m_char, "R4 char value", char_out, m_char);
  endtask

  task automatic pulse_ext();
    @(negedge clk);
    ext_sync = 1;
    if (len_sel == 2'b00 && m_hunt) begin m_hunt = 0; m_cnt = 0; end
    @(negedge clk);
    ext_sync = 0;
    chk(in_hunt == m_hunt, "R3/R9 ext sync", in_hunt, m_hunt);
  endtask

  task automatic restart();
    @(negedge clk);
    hunt_restart = 1;
    m_hunt = 1; m_fill = 0; m_cnt = 0;
    @(negedge clk);
    hunt_restart = 0;
    chk(in_hunt == 1'b1, "R5 restart hunt", in_hunt, 1);
    chk(char_stb == 1'b0, "R5 no strobe", char_stb, 0);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic tx_check(input logic [1:0] s, input logic [15:0] p);
    @(negedge clk);
    len_sel = s; sync_pat = p; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    if (s == 2'b00) begin
      chk(tx_pre_done == 1'b1, "R7 mode0 ack", tx_pre_done, 1);
      chk(tx_active == 1'b0, "R7 mode0 no bits", tx_active, 0);
      @(negedge clk);
      chk(tx_pre_done == 1'b0, "R7 mode0 ack pulse", tx_pre_done, 0);
      return;
    end
    for (int i = 0; i < 16; i++) begin
      chk(tx_active == 1'b1, "R6 active", tx_active, 1);
      chk(tx_bit == p[i], "R6 preamble bit", tx_bit, p[i]);
      chk(tx_pre_done == (i == 15), "R7 done timing", tx_pre_done, i == 15);
      @(negedge clk);
      tx_start = (i == 4 || i == 14);
    end
    tx_start = 0;
    chk(tx_active == 1'b0, "R8 length unchanged", tx_active, 0);
    chk(tx_bit == 1'b1, "R8 idle after", tx_bit, 1);
  endtask

  initial begin
    void'($urandom(1234));
    m_win = '0; m_fill = 0; m_cnt = 0; m_hunt = 1; m_char = '0;
    repeat (3) @(negedge clk);
    chk(in_hunt == 1'b1, "R1 hunt", in_hunt, 1);
    chk(char_stb == 1'b0, "R1 strobe", char_stb, 0);
    chk(tx_active == 1'b0, "R1 tx active", tx_active, 0);
    chk(tx_pre_done == 1'b0, "R1 done", tx_pre_done, 0);
    chk(tx_bit == 1'b1, "R1 tx idle", tx_bit, 1);
    rst_n = 1;

    // R2: directed early-match guard: 16-bit zero pattern needs 16 bits
    len_sel = 2'b11; sync_pat = 16'h0000;
    restart();
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    send_byte(8'hA5);

    // R2/R4/R5: random rounds over every pattern length
    for (int r = 0; r < 30; r++) begin
      len_sel = 2'($urandom_range(1, 3));
      sync_pat = 16'($urandom());
      restart();
      for (int i = 0, n = $urandom_range(0, 20); i < n; i++) send_bit(1'($urandom()));
      pulse_ext(); // R9: ignored in pattern mode
      for (int i = 0; i < plen(len_sel); i++) send_bit(sync_pat[i]);
      for (int c = 0, k = $urandom_range(1, 4); c < k; c++) send_byte(8'($urandom()));
      for (int i = 0, n = $urandom_range(0, 7); i < n; i++) send_bit(1'($urandom()));
    end

    // R3/R9: external strobe mode
    len_sel = 2'b00; sync_pat = 16'hFFFF;
    restart();
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    pulse_ext();
    send_byte(8'h3C);
    send_bit(1'b1); send_bit(1'b0);
    pulse_ext();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_byte(8'h81);

    // R5: restart mid-character, then realign
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    restart();
    send_bit(1'b1);
    pulse_ext();
    send_byte(8'h5A);

    // R6/R7/R8: preamble transmit
    tx_check(2'b01, 16'h6666);
    tx_check(2'b10, 16'hD2D2);
    tx_check(2'b11, 16'h8E31);
    tx_check(2'b00, 16'h1234);
    for (int r = 0; r < 4; r++) tx_check(2'($urandom_range(1, 3)), 16'($urandom()));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog got=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule